// File: doc/BRIEF.md
# SMBus Write-Word Slave Receiver

This block is the receive side of a small two-wire slave that loads a 10-bit output register. It watches already-synchronized SCL and SDA samples at system-clock rate. It detects START and STOP conditions, collects bits on rising SCL edges and decodes a 7-bit address. It acknowledges by asking the pad to pull SDA low. It accepts a Send Byte frame, which carries a command byte only, and a Write Word frame, which carries a command byte, then the low data byte, then the high data byte. It also answers a broadcast address that several devices share. On that address the read/write position carries a one-bit quick-command flag.

The block does not update the analog output itself. It reports what it received as one-cycle strobes with registered payloads: the three command bits, the 10-bit word and the sync flag. It also reports every START and STOP, so that a downstream latch controller can choose when to apply the values. Interrupted frames are resolved one byte at a time. A command byte that has already been acknowledged survives an early START or STOP, while partial data is dropped. A repeated START is legal, so a master can load several devices and close them all with one STOP.

Top module: `smb_wword_rx`

## Requirements
- R1: For an address byte whose upper seven bits equal the device address (7'b0100000, or 7'b0100001 when `ALT_ADDR` is 1) and whose bit 0 is 0, `sda_low_o` rises one clock after the SCL falling edge that ends the eighth bit. It stays high through the ninth SCL clock.
- R2: An address byte naming another address, or naming the device address with bit 0 set to 1, gets no acknowledge. After it, no later byte is acknowledged and no strobe other than a START/STOP event is produced until the next START.
- R3: With `ALT_ADDR` = 1 the block acknowledges 7'b0100001 and ignores 7'b0100000.
- R4: In a Send Byte frame, `cmd_stb_o` pulses for one clock, one clock after STOP is detected. `cmd_o[0]`, `cmd_o[1]` and `cmd_o[2]` take command-byte bits 0, 1 and 2. Bits 7 to 3 of the command byte have no effect.
- R5: In a Write Word frame, `data_stb_o` and `cmd_stb_o` pulse together one clock after the SCL rising edge of the fourth acknowledge. `data_o[7:0]` is the first data byte, and `data_o[9:8]` are bits 1:0 of the second data byte. The upper six bits of the second data byte are ignored. A fifth byte in the same frame is not acknowledged.
- R6: A START or STOP that arrives after the command byte's acknowledge but before the high data byte's acknowledge produces `cmd_stb_o` with the kept command one clock after the event. `data_stb_o` does not pulse and `data_o` is unchanged.
- R7: A START or STOP that arrives before the command byte's acknowledge produces no `cmd_stb_o` and no `data_stb_o`.
- R8: The sync address 7'b1111110 is acknowledged whatever bit 0 holds. `sync_stb_o` pulses one clock after the SCL rising edge of its acknowledge, and `sync_flag_o` holds that bit 0. The next byte of that frame is not acknowledged.
- R9: A repeated START with no STOP in between starts a new address phase. Results already strobed from the earlier frame stay on the outputs.
- R10: `start_evt_o` or `stop_evt_o` pulses for exactly one clock, one clock after SDA falls or rises while SCL is high.
- R11: `sda_low_o` falls one clock after the SCL falling edge that ends the acknowledge bit. It is never high outside an acknowledge.
- R12: After reset every output is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (bus value) |
| sda_low_o | output | 1 | 1 asks the pad to pull SDA low |
| cmd_stb_o | output | 1 | One-clock pulse: command bits are valid |
| cmd_o | output | 3 | Command bits {BG, SD, SY} |
| data_stb_o | output | 1 | One-clock pulse: full data word is valid |
| data_o | output | 10 | Received data word |
| sync_stb_o | output | 1 | One-clock pulse: sync quick command seen |
| sync_flag_o | output | 1 | Flag carried by the last sync quick command |
| start_evt_o | output | 1 | One-clock pulse per START |
| stop_evt_o | output | 1 | One-clock pulse per STOP |

## Verification
A wrong phase or slot shows at the pad first. An acknowledge that comes early, comes late, lands on the wrong byte or is never released shows on `sda_low_o` within the same SCL bit, one system clock after the SCL edge that should have moved it. Losing track of whether a command is pending shows on `cmd_stb_o`. It either fails to pulse, or pulses at the STOP or START that ends an interrupted frame or one clock after that event. A corrupted bit count or byte register shows as a wrong `data_o` or `cmd_o` value at the strobe of that same frame. A second instance with the alternate address shares the modelled bus, so an acknowledge given to the wrong address is caught at once.

// File: rtl/smb_rx_pkg.sv
package smb_rx_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 10;
    localparam int CMD_W   = 3;
    localparam int HI_W    = DATA_W - BYTE_W;

    localparam logic [ADDR_W-1:0] DEV_ADDR_MAIN = 7'b0100000;
    localparam logic [ADDR_W-1:0] DEV_ADDR_ALT  = 7'b0100001;
    localparam logic [ADDR_W-1:0] SYNC_ADDR     = 7'b1111110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BITS,
        PH_WAIT,
        PH_ACK,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        SL_ADDR,
        SL_CMD,
        SL_DLO,
        SL_DHI
    } slot_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon
    import smb_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    line_t line_d, line_q;

    always_comb begin
        line_d     = line_q;
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            line_q <= line_d;
        end
    end

    assign scl_rise_o = scl_i & ~line_q.scl;
    assign scl_fall_o = ~scl_i & line_q.scl;
    assign start_o    = scl_i & line_q.scl & line_q.sda & ~sda_i;
    assign stop_o     = scl_i & line_q.scl & ~line_q.sda & sda_i;

endmodule

// File: rtl/smb_bit_shift.sv
module smb_bit_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         rise_i,
    input  logic         bit_i,
    output logic [W-1:0] byte_o,
    output logic         full_o
);

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  sh;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (clr_i) begin
            shf_d.cnt = '0;
        end else if (en_i && rise_i && (shf_q.cnt != CW'(W))) begin
            shf_d.sh  = {shf_q.sh[W-2:0], bit_i};
            shf_d.cnt = shf_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign byte_o = shf_q.sh;
    assign full_o = (shf_q.cnt == CW'(W));

    // R1
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shf_q.cnt <= CW'(W));

endmodule

// File: rtl/smb_frame_ctl.sv
module smb_frame_ctl
    import smb_rx_pkg::*;
#(
    parameter bit ALT_ADDR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              full_i,
    output logic              shf_clr_o,
    output logic              shf_en_o,
    output logic              sda_low_o,
    output logic              cmd_stb_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              data_stb_o,
    output logic [DATA_W-1:0] data_o,
    output logic              sync_stb_o,
    output logic              sync_flag_o,
    output logic              start_evt_o,
    output logic              stop_evt_o
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ALT_ADDR ? DEV_ADDR_ALT : DEV_ADDR_MAIN;

    typedef struct packed {
        phase_e              ph;
        slot_e               slot;
        logic                sync_fr;
        logic                sync_bit;
        logic [CMD_W-1:0]    cmd_pend;
        logic                cmd_held;
        logic [BYTE_W-1:0]   lo;
        logic [HI_W-1:0]     hi;
        logic                drive;
        logic                cmd_stb;
        logic [CMD_W-1:0]    cmd;
        logic                data_stb;
        logic [DATA_W-1:0]   data;
        logic                sync_stb;
        logic                sync_flag;
        logic                start_evt;
        logic                stop_evt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] rx_addr;
    logic              rx_rw;

    assign rx_addr = byte_i[BYTE_W-1:1];
    assign rx_rw   = byte_i[0];

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.cmd_stb   = 1'b0;
        ctl_d.data_stb  = 1'b0;
        ctl_d.sync_stb  = 1'b0;
        ctl_d.start_evt = 1'b0;
        ctl_d.stop_evt  = 1'b0;

        if (start_i || stop_i) begin
            // frame ends: keep an acknowledged command, drop partial data
            if (ctl_q.cmd_held) begin
                ctl_d.cmd_stb  = 1'b1;
                ctl_d.cmd      = ctl_q.cmd_pend;
                ctl_d.cmd_held = 1'b0;
            end
            ctl_d.drive     = 1'b0;
            ctl_d.start_evt = start_i;
            ctl_d.stop_evt  = stop_i;
            ctl_d.ph        = start_i ? PH_BITS : PH_IDLE;
            ctl_d.slot      = SL_ADDR;
            ctl_d.sync_fr   = 1'b0;
        end else begin
            unique case (ctl_q.ph)
                PH_BITS: begin
                    if (full_i) begin
                        unique case (ctl_q.slot)
                            SL_ADDR: begin
                                if (rx_addr == MY_ADDR && !rx_rw) begin
                                    ctl_d.ph      = PH_WAIT;
                                    ctl_d.sync_fr = 1'b0;
                                end else if (rx_addr == SYNC_ADDR) begin
                                    ctl_d.ph       = PH_WAIT;
                                    ctl_d.sync_fr  = 1'b1;
                                    ctl_d.sync_bit = rx_rw;
                                end else begin
                                    ctl_d.ph = PH_IDLE;
                                end
                            end
                            SL_CMD: begin
                                ctl_d.cmd_pend = byte_i[CMD_W-1:0];
                                ctl_d.ph       = PH_WAIT;
                            end
                            SL_DLO: begin
                                ctl_d.lo = byte_i;
                                ctl_d.ph = PH_WAIT;
                            end
                            SL_DHI: begin
                                ctl_d.hi = byte_i[HI_W-1:0];
                                ctl_d.ph = PH_WAIT;
                            end
                            default: ctl_d.ph = PH_IDLE;
                        endcase
                    end
                end
                PH_WAIT: begin
                    if (scl_fall_i) begin
                        ctl_d.drive = 1'b1;
                        ctl_d.ph    = PH_ACK;
                    end
                end
                PH_ACK: begin
                    if (scl_rise_i) begin
                        ctl_d.ph = PH_HOLD;
                        unique case (ctl_q.slot)
                            SL_ADDR: begin
                                if (ctl_q.sync_fr) begin
                                    ctl_d.sync_stb  = 1'b1;
                                    ctl_d.sync_flag = ctl_q.sync_bit;
                                end
                            end
                            SL_CMD: begin
                                ctl_d.cmd_held = 1'b1;
                            end
                            SL_DHI: begin
                                ctl_d.cmd_stb  = 1'b1;
                                ctl_d.cmd      = ctl_q.cmd_pend;
                                ctl_d.data_stb = 1'b1;
                                ctl_d.data     = {ctl_q.hi, ctl_q.lo};
                                ctl_d.cmd_held = 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
                PH_HOLD: begin
                    if (scl_fall_i) begin
                        ctl_d.drive = 1'b0;
                        if (ctl_q.sync_fr || ctl_q.slot == SL_DHI) begin
                            ctl_d.ph = PH_IDLE;
                        end else begin
                            ctl_d.ph   = PH_BITS;
                            ctl_d.slot = slot_e'(ctl_q.slot + 2'd1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, slot: SL_ADDR, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign shf_clr_o   = start_i | stop_i | ((ctl_q.ph == PH_BITS) & full_i);
    assign shf_en_o    = (ctl_q.ph == PH_BITS);
    assign sda_low_o   = ctl_q.drive;
    assign cmd_stb_o   = ctl_q.cmd_stb;
    assign cmd_o       = ctl_q.cmd;
    assign data_stb_o  = ctl_q.data_stb;
    assign data_o      = ctl_q.data;
    assign sync_stb_o  = ctl_q.sync_stb;
    assign sync_flag_o = ctl_q.sync_flag;
    assign start_evt_o = ctl_q.start_evt;
    assign stop_evt_o  = ctl_q.stop_evt;

    // R11
    drive_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.drive |-> (ctl_q.ph == PH_ACK || ctl_q.ph == PH_HOLD));

    // R1
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.drive) |-> $past(scl_fall_i));

    // R11
    release_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.drive) |-> $past(scl_fall_i || start_i || stop_i));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_IDLE) |-> !ctl_q.drive);

    // R8
    sync_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.sync_stb |-> ctl_q.drive);

endmodule

// File: rtl/smb_wword_rx.sv
module smb_wword_rx
    import smb_rx_pkg::*;
#(
    parameter bit ALT_ADDR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_low_o,
    output logic              cmd_stb_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              data_stb_o,
    output logic [DATA_W-1:0] data_o,
    output logic              sync_stb_o,
    output logic              sync_flag_o,
    output logic              start_evt_o,
    output logic              stop_evt_o
);

    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              shf_clr, shf_en, shf_full;
    logic [BYTE_W-1:0] shf_byte;

    smb_line_mon line_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    smb_bit_shift #(.W(BYTE_W)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (shf_clr),
        .en_i   (shf_en),
        .rise_i (scl_rise),
        .bit_i  (sda_i),
        .byte_o (shf_byte),
        .full_o (shf_full)
    );

    smb_frame_ctl #(.ALT_ADDR(ALT_ADDR)) ctl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .byte_i      (shf_byte),
        .full_i      (shf_full),
        .shf_clr_o   (shf_clr),
        .shf_en_o    (shf_en),
        .sda_low_o   (sda_low_o),
        .cmd_stb_o   (cmd_stb_o),
        .cmd_o       (cmd_o),
        .data_stb_o  (data_stb_o),
        .data_o      (data_o),
        .sync_stb_o  (sync_stb_o),
        .sync_flag_o (sync_flag_o),
        .start_evt_o (start_evt_o),
        .stop_evt_o  (stop_evt_o)
    );

endmodule

// File: tb/smb_wword_rx_tb_top.sv
module smb_wword_rx_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;

    logic       drv_main, drv_alt;
    logic       cmd_stb, data_stb, sync_stb, sync_flag, start_evt, stop_evt;
    logic [2:0] cmd;
    logic [9:0] data;
    logic       a_cmd_stb, a_data_stb, a_sync_stb, a_sync_flag, a_start, a_stop;
    logic [2:0] a_cmd;
    logic [9:0] a_data;

    assign sda_bus = sda_m & ~drv_main & ~drv_alt;

    smb_wword_rx dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_low_o(drv_main), .cmd_stb_o(cmd_stb), .cmd_o(cmd),
        .data_stb_o(data_stb), .data_o(data), .sync_stb_o(sync_stb),
        .sync_flag_o(sync_flag), .start_evt_o(start_evt), .stop_evt_o(stop_evt)
    );

    smb_wword_rx #(.ALT_ADDR(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_low_o(drv_alt), .cmd_stb_o(a_cmd_stb), .cmd_o(a_cmd),
        .data_stb_o(a_data_stb), .data_o(a_data), .sync_stb_o(a_sync_stb),
        .sync_flag_o(a_sync_flag), .start_evt_o(a_start), .stop_evt_o(a_stop)
    );

    // reference model state
    logic       exp_drv = 0, exp_drv_alt = 0;
    logic       exp_cmd_stb = 0, exp_data_stb = 0, exp_sync_stb = 0;
    logic       exp_start = 0, exp_stop = 0, exp_flag = 0;
    logic [2:0] exp_cmd = '0;
    logic [9:0] exp_data = '0;
    logic       m_held = 0;
    logic [2:0] m_cmd = '0;
    logic [7:0] m_lo = '0;
    string      cur_req = "R12";
    int         n_cmp = 0;
    int         n_bad = 0;

    task automatic cmp(string nm, logic [9:0] got, logic [9:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, nm, got, exp, $time);
        end
    endtask

    // compare every clock, 5 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                cmp("sda_low", 10'(drv_main), 10'(exp_drv));
                cmp("sda_low_alt", 10'(drv_alt), 10'(exp_drv_alt));
                cmp("cmd_stb", 10'(cmd_stb), 10'(exp_cmd_stb));
                cmp("cmd", 10'(cmd), 10'(exp_cmd));
                cmp("data_stb", 10'(data_stb), 10'(exp_data_stb));
                cmp("data", data, exp_data);
                cmp("sync_stb", 10'(sync_stb), 10'(exp_sync_stb));
                cmp("sync_flag", 10'(sync_flag), 10'(exp_flag));
                cmp("start_evt", 10'(start_evt), 10'(exp_start));
                cmp("stop_evt", 10'(stop_evt), 10'(exp_stop));
                exp_cmd_stb  = 0;
                exp_data_stb = 0;
                exp_sync_stb = 0;
                exp_start    = 0;
                exp_stop     = 0;
            end
        end
    end

    task automatic pad();
        repeat (3) @(negedge clk);
    endtask

    task automatic flush();
        if (m_held) begin
            exp_cmd_stb = 1;
            exp_cmd     = m_cmd;
            m_held      = 0;
        end
    endtask

    task automatic start_cond();
        @(negedge clk); sda_m = 1; pad();
        @(negedge clk); scl_m = 1; pad();
        @(negedge clk); sda_m = 0; exp_start = 1; flush(); pad();
        @(negedge clk); scl_m = 0; pad();
    endtask

    task automatic stop_cond();
        @(negedge clk); sda_m = 0; pad();
        @(negedge clk); scl_m = 1; pad();
        @(negedge clk); sda_m = 1; exp_stop = 1; flush(); pad();
    endtask

    task automatic send_bits(logic [7:0] b, int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk); sda_m = b[i]; pad();
            @(negedge clk); scl_m = 1; pad();
            @(negedge clk); scl_m = 0; pad();
        end
    endtask

    // kind: 0 plain, 1 sync address, 2 command, 3 low data, 4 high data
    task automatic send_byte(logic [7:0] b, bit ack_m, bit ack_a, int kind);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); sda_m = b[i]; pad();
            @(negedge clk); scl_m = 1; pad();
            @(negedge clk); scl_m = 0;
            if (i == 0) begin
                exp_drv     = ack_m;
                exp_drv_alt = ack_a;
            end
            pad();
        end
        @(negedge clk); sda_m = 1; pad();
        @(negedge clk); scl_m = 1;
        if (ack_m) begin
            case (kind)
                1: begin exp_sync_stb = 1; exp_flag = b[0]; end
                2: begin m_held = 1; m_cmd = b[2:0]; end
                3: m_lo = b;
                4: begin
                    exp_cmd_stb  = 1; exp_cmd = m_cmd;
                    exp_data_stb = 1; exp_data = {b[1:0], m_lo};
                    m_held       = 0;
                end
                default: ;
            endcase
        end
        pad();
        @(negedge clk); scl_m = 0; exp_drv = 0; exp_drv_alt = 0; pad();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R12: the first compared cycles hold the reset state
        pad();

        // R1 R4 R10: Send Byte, upper command bits set but ignored
        cur_req = "R4";
        start_cond();
        send_byte(8'h40, 1, 0, 0);
        send_byte(8'hFD, 1, 0, 2);
        stop_cond();

        // R5: Write Word, high byte upper bits ignored, fifth byte not acked
        cur_req = "R5";
        start_cond();
        send_byte(8'h40, 1, 0, 0);
        send_byte(8'h02, 1, 0, 2);
        send_byte(8'hA5, 1, 0, 3);
        send_byte(8'hFE, 1, 0, 4);
        send_byte(8'h33, 0, 0, 0);
        stop_cond();

        // R6: STOP after the low data byte keeps the command only
        cur_req = "R6";
        start_cond();
        send_byte(8'h40, 1, 0, 0);
        send_byte(8'h04, 1, 0, 2);
        send_byte(8'h11, 1, 0, 3);
        stop_cond();

        // R6 with repeated START inside the high byte, then R3 alternate address
        cur_req = "R6";
        start_cond();
        send_byte(8'h40, 1, 0, 0);
        send_byte(8'h01, 1, 0, 2);
        send_byte(8'h22, 1, 0, 3);
        send_bits(8'hFF, 5);
        start_cond();
        cur_req = "R3";
        send_byte(8'h42, 0, 1, 0);
        send_byte(8'h07, 0, 1, 0);
        stop_cond();

        // R7: STOP inside the command byte
        cur_req = "R7";
        start_cond();
        send_byte(8'h40, 1, 0, 0);
        send_bits(8'h06, 5);
        stop_cond();

        // R2: foreign address, then own address with read bit
        cur_req = "R2";
        start_cond();
        send_byte(8'h54, 0, 0, 0);
        send_byte(8'hFF, 0, 0, 0);
        stop_cond();
        start_cond();
        send_byte(8'h41, 0, 0, 0);
        send_byte(8'h00, 0, 0, 0);
        stop_cond();

        // R8: sync quick command, both flag values
        cur_req = "R8";
        start_cond();
        send_byte(8'hFD, 1, 1, 1);
        send_byte(8'h12, 0, 0, 0);
        stop_cond();
        start_cond();
        send_byte(8'hFC, 1, 1, 1);
        stop_cond();

        // R9 R11: word load, repeated START, sync, one final STOP
        cur_req = "R9";
        start_cond();
        send_byte(8'h40, 1, 0, 0);
        send_byte(8'h03, 1, 0, 2);
        send_byte(8'h5A, 1, 0, 3);
        send_byte(8'h01, 1, 0, 4);
        start_cond();
        send_byte(8'hFD, 1, 1, 1);
        stop_cond();
        pad();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule